// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block produces the pin-level waveforms of an 8-bit NAND flash port. A client asks for one bus cycle at a time: latch a command byte, latch one address byte, write one data byte, or read one data byte. The block then walks a fixed series of pin states. Each state is a four-bit control word that sets the command latch, the address latch and the two active-low strobes. The block pulses `ack` once the last state of the cycle has completed. For a read, it returns the byte that was on the bus while the read strobe was low.

Each pin state is held for `step_hold + 1` clocks. Setup and hold margins are therefore set by a port value, not by a bus clock. An address byte can be marked as the final byte of an address phase. Only a final byte drops the address latch afterwards, so an address phase made of several bytes keeps the latch high between its bytes. The ready/busy line from the flash device passes through a parameterised synchroniser and is reported on `rb_ready`.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset the pins rest in the idle word: `pin_re_n`=1, `pin_we_n`=1, `pin_ale`=0, `pin_cle`=0. Also after reset `pin_dq_oe`=0, `busy`=0 and `ack`=0.
- R2: A command request (`req_op`=0) steps the control word {RE_n,ALE,WE_n,CLE} through 1011, 1001, 1011, 1010.
- R3: An address request (`req_op`=1) steps through 1100 then 1110. With `req_last`=1 it adds a third step, 1010. With `req_last`=0 the pins stay at 1110 after the cycle.
- R4: A write request (`req_op`=2) steps through 1000 then 1010.
- R5: A read request (`req_op`=3) steps through 0010 then 1010. `rd_byte` takes the value of `pin_dq_in` present at the final clock edge of the RE-low step. It holds that value at `ack`.
- R6: Every step lasts exactly `step_hold`+1 clocks. This includes `step_hold`=0 and the largest value `step_hold` can take.
- R7: `pin_dq_oe` is high during command, address and write cycles, and `pin_dq_out` then equals the requested byte. During read cycles and when idle, `pin_dq_oe` is low.
- R8: `ack` is high for exactly one clock, in the clock after the last step of a cycle ends. `busy` is low in that clock.
- R9: A request is taken only while `busy` is low. While a cycle runs, `req_valid`, `req_op` and `req_byte` have no effect on the pin sequence or on the driven byte.
- R10: `rb_ready` follows `pin_rb_n` after `RB_SYNC_STAGES` clock edges (2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request a bus cycle |
| req_op | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_byte | input | DATA_W | Byte to drive for command, address and write |
| req_last | input | 1 | Address byte ends the address phase |
| step_hold | input | HOLD_W | Extra clocks each pin state is held |
| busy | output | 1 | A cycle is in progress |
| ack | output | 1 | One-clock pulse at the end of a cycle |
| rd_byte | output | DATA_W | Byte captured by the last read |
| rb_ready | output | 1 | Synchronised ready/busy (1 = ready) |
| pin_cle | output | 1 | Command latch enable |
| pin_ale | output | 1 | Address latch enable |
| pin_we_n | output | 1 | Write strobe, active low |
| pin_re_n | output | 1 | Read strobe, active low |
| pin_dq_out | output | DATA_W | Data bus output value |
| pin_dq_oe | output | 1 | Data bus output enable |
| pin_dq_in | input | DATA_W | Data bus input value |
| pin_rb_n | input | 1 | Ready/busy from the device |

## Verification
Random sequences of all four cycle types are run with random bytes and with hold values from zero to the maximum. This separates errors in the step table from errors in the hold timer. In some runs a different request is held on the inputs while a cycle is running. This shows whether an early accept or a byte overwrite takes place. Read cycles change the input bus on every clock, so a sample taken at the wrong edge returns a different byte. Address bytes with and without the final flag show whether the latch is released at the right point.

// File: rtl/nandcg_pkg.sv
package nandcg_pkg;

   typedef enum logic [1:0] {
      OP_CMD   = 2'd0,
      OP_ADDR  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } nand_op_e;

   localparam int CTRL_W   = 4;
   localparam int B_CLE    = 0;
   localparam int B_WE_N   = 1;
   localparam int B_ALE    = 2;
   localparam int B_RE_N   = 3;

   localparam logic [CTRL_W-1:0] W_IDLE = 4'b1010;

   // Pin word for step idx of a cycle
   function automatic logic [CTRL_W-1:0] step_word(nand_op_e op, logic [1:0] idx);
      logic [CTRL_W-1:0] w;
      w = W_IDLE;
      case (op)
         OP_CMD: begin
            case (idx)
               2'd0:    w = 4'b1011;
               2'd1:    w = 4'b1001;
               2'd2:    w = 4'b1011;
               default: w = 4'b1010;
            endcase
         end
         OP_ADDR: begin
            case (idx)
               2'd0:    w = 4'b1100;
               2'd1:    w = 4'b1110;
               default: w = 4'b1010;
            endcase
         end
         OP_WRITE: w = (idx == 2'd0) ? 4'b1000 : 4'b1010;
         OP_READ:  w = (idx == 2'd0) ? 4'b0010 : 4'b1010;
         default:  w = W_IDLE;
      endcase
      return w;
   endfunction

   // Index of the final step of a cycle
   function automatic logic [1:0] final_step(nand_op_e op, logic fin);
      logic [1:0] n;
      case (op)
         OP_CMD:  n = 2'd3;
         OP_ADDR: n = fin ? 2'd2 : 2'd1;
         default: n = 2'd1;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/nandcg_timer.sv
module nandcg_timer #(
   parameter int HOLD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HOLD_W-1:0] hold,
   output logic              expire
);

   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= hold;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == '0);

   // A loaded count must drain by one per clock (R6)
   p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expire) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/nandcg_seq.sv
module nandcg_seq
   import nandcg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  nand_op_e          req_op,
   input  logic              req_fin,
   input  logic              expire,
   output logic              accept,
   output logic              step_load,
   output logic              finish,
   output logic              capture,
   output logic              busy,
   output logic              ack,
   output logic [CTRL_W-1:0] ctrl
);

   nand_op_e   op_q;
   logic       fin_q;
   logic [1:0] idx_q;
   logic       at_last;

   assign accept    = req_valid && !busy;
   assign at_last   = (idx_q == final_step(op_q, fin_q));
   assign finish    = busy && expire && at_last;
   assign step_load = accept || (busy && expire && !at_last);
   assign capture   = busy && expire && (op_q == OP_READ) && (idx_q == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         ack   <= 1'b0;
         op_q  <= OP_CMD;
         fin_q <= 1'b0;
         idx_q <= 2'd0;
         ctrl  <= W_IDLE;
      end else begin
         ack <= 1'b0;
         if (accept) begin
            busy  <= 1'b1;
            op_q  <= req_op;
            fin_q <= req_fin;
            idx_q <= 2'd0;
            ctrl  <= step_word(req_op, 2'd0);
         end else if (finish) begin
            busy <= 1'b0;
            ack  <= 1'b1;
         end else if (busy && expire) begin
            idx_q <= idx_q + 2'd1;
            ctrl  <= step_word(op_q, idx_q + 2'd1);
         end
      end
   end

   // Acknowledge is a single-clock pulse (R8)
   p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // Acknowledge only follows a running cycle (R8)
   p_ack_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (!busy && $past(busy)));

   // The two strobes are never low together (R2)
   p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ctrl[B_WE_N] && !ctrl[B_RE_N]));

   // Command and address latches are never high together (R3)
   p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl[B_CLE] && ctrl[B_ALE]));

endmodule

// File: rtl/nandcg_pins.sv
module nandcg_pins
   import nandcg_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int RB_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  nand_op_e          req_op,
   input  logic [DATA_W-1:0] req_byte,
   input  logic              finish,
   input  logic              capture,
   input  logic [DATA_W-1:0] pin_dq_in,
   input  logic              pin_rb_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rd_byte,
   output logic              rb_ready
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_out  <= '0;
         dq_oe   <= 1'b0;
         rd_byte <= '0;
      end else begin
         if (accept) begin
            dq_oe <= (req_op != OP_READ);
            if (req_op != OP_READ) begin
               dq_out <= req_byte;
            end
         end else if (finish) begin
            dq_oe <= 1'b0;
         end
         if (capture) begin
            rd_byte <= pin_dq_in;
         end
      end
   end

   generate
      if (RB_SYNC_STAGES == 0) begin : g_rb_direct
         assign rb_ready = pin_rb_n;
      end else begin : g_rb_sync
         logic [RB_SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= pin_rb_n;
               for (int i = 1; i < RB_SYNC_STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign rb_ready = sh_q[RB_SYNC_STAGES-1];
      end
   endgenerate

   // Driven byte cannot change while the bus is driven (R9)
   p_dq_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

   // Read data is only replaced while the bus is released (R5)
   p_rd_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> !dq_oe);

endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
   import nandcg_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int HOLD_W         = 4,
   parameter int RB_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [DATA_W-1:0] req_byte,
   input  logic              req_last,
   input  logic [HOLD_W-1:0] step_hold,
   output logic              busy,
   output logic              ack,
   output logic [DATA_W-1:0] rd_byte,
   output logic              rb_ready,
   output logic              pin_cle,
   output logic              pin_ale,
   output logic              pin_we_n,
   output logic              pin_re_n,
   output logic [DATA_W-1:0] pin_dq_out,
   output logic              pin_dq_oe,
   input  logic [DATA_W-1:0] pin_dq_in,
   input  logic              pin_rb_n
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("nand_cycle_gen: DATA_W must be at least 1");
      end
      if (HOLD_W < 1 || HOLD_W > 16) begin : g_bad_hold_w
         $error("nand_cycle_gen: HOLD_W must be within 1..16");
      end
      if (RB_SYNC_STAGES < 0 || RB_SYNC_STAGES > 4) begin : g_bad_sync
         $error("nand_cycle_gen: RB_SYNC_STAGES must be within 0..4");
      end
   endgenerate

   nand_op_e          op_in;
   logic              accept;
   logic              step_load;
   logic              finish;
   logic              capture;
   logic              expire;
   logic [CTRL_W-1:0] ctrl;

   assign op_in = nand_op_e'(req_op);

   nandcg_timer #(.HOLD_W(HOLD_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (step_load),
      .hold   (step_hold),
      .expire (expire)
   );

   nandcg_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_op    (op_in),
      .req_fin   (req_last),
      .expire    (expire),
      .accept    (accept),
      .step_load (step_load),
      .finish    (finish),
      .capture   (capture),
      .busy      (busy),
      .ack       (ack),
      .ctrl      (ctrl)
   );

   nandcg_pins #(.DATA_W(DATA_W), .RB_SYNC_STAGES(RB_SYNC_STAGES)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_op    (op_in),
      .req_byte  (req_byte),
      .finish    (finish),
      .capture   (capture),
      .pin_dq_in (pin_dq_in),
      .pin_rb_n  (pin_rb_n),
      .dq_out    (pin_dq_out),
      .dq_oe     (pin_dq_oe),
      .rd_byte   (rd_byte),
      .rb_ready  (rb_ready)
   );

   assign pin_cle  = ctrl[B_CLE];
   assign pin_we_n = ctrl[B_WE_N];
   assign pin_ale  = ctrl[B_ALE];
   assign pin_re_n = ctrl[B_RE_N];

   // Bus is released whenever the read strobe is low (R7)
   p_oe_off_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_re_n |-> !pin_dq_oe);

   // Bus is released while idle (R7)
   p_oe_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pin_dq_oe);

   // Write strobe low only with the bus driven (R7)
   p_we_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_we_n |-> pin_dq_oe);

endmodule

// File: tb/nand_cycle_gen_tb.sv
module nand_cycle_gen_tb;

   localparam int DW = 8;
   localparam int HW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [DW-1:0] req_byte = '0;
   logic          req_last = 1'b0;
   logic [HW-1:0] step_hold = '0;
   logic          busy, ack, rb_ready;
   logic [DW-1:0] rd_byte, pin_dq_out;
   logic          pin_cle, pin_ale, pin_we_n, pin_re_n, pin_dq_oe;
   logic [DW-1:0] pin_dq_in = '0;
   logic          pin_rb_n = 1'b1;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   nand_cycle_gen #(.DATA_W(DW), .HOLD_W(HW), .RB_SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_byte(req_byte), .req_last(req_last), .step_hold(step_hold),
      .busy(busy), .ack(ack), .rd_byte(rd_byte), .rb_ready(rb_ready),
      .pin_cle(pin_cle), .pin_ale(pin_ale), .pin_we_n(pin_we_n),
      .pin_re_n(pin_re_n), .pin_dq_out(pin_dq_out), .pin_dq_oe(pin_dq_oe),
      .pin_dq_in(pin_dq_in), .pin_rb_n(pin_rb_n)
   );

   function automatic logic [3:0] pins_word();
      return {pin_re_n, pin_ale, pin_we_n, pin_cle};
   endfunction

   function automatic int exp_steps(int k, bit fin);
      if (k == 0) return 4;
      if (k == 1) return fin ? 3 : 2;
      return 2;
   endfunction

   function automatic logic [3:0] exp_word(int k, int i);
      case (k)
         0: case (i) 0: return 4'b1011; 1: return 4'b1001; 2: return 4'b1011; default: return 4'b1010; endcase
         1: case (i) 0: return 4'b1100; 1: return 4'b1110; default: return 4'b1010; endcase
         2: return (i == 0) ? 4'b1000 : 4'b1010;
         default: return (i == 0) ? 4'b0010 : 4'b1010;
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic string seq_req(int k);
      case (k)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         default: return "R5";
      endcase
   endfunction

   // Run one cycle; jam holds a different request on the inputs while busy
   task automatic run_op(int k, logic [DW-1:0] b, bit fin, int hold, bit jam);
      int s = 0;
      int seq_err = 0;
      int oe_err = 0;
      int bad_s = -1;
      logic [DW-1:0] exp_rd = '0;
      int per = hold + 1;
      int total = exp_steps(k, fin) * per;
      @(negedge clk);
      step_hold = hold[HW-1:0];
      req_valid = 1'b1;
      req_op = k[1:0];
      req_byte = b;
      req_last = fin;
      @(negedge clk);
      if (jam) begin
         req_op = 2'd2;
         req_byte = ~b;
         req_last = ~fin;
      end else begin
         req_valid = 1'b0;
      end
      while (!ack && s < 400) begin
         if (s >= total || pins_word() != exp_word(k, s / per)) begin
            seq_err++;
            if (bad_s < 0) bad_s = s;
         end
         if (pin_dq_oe != (k != 3) || (k != 3 && pin_dq_out != b)) oe_err++;
         pin_dq_in = DW'($urandom);
         if (k == 3 && !pin_re_n) exp_rd = pin_dq_in;
         s++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(seq_err == 0, seq_req(k), bad_s, s);
      chk(s == total, "R6", s, total);
      chk(oe_err == 0, "R7", oe_err, 0);
      chk(ack && !busy, "R8", {ack, busy}, 2'b10);
      if (k == 3) chk(rd_byte == exp_rd, "R5", rd_byte, exp_rd);
      @(negedge clk);
      chk(!ack && !busy, jam ? "R9" : "R8", {ack, busy}, 2'b00);
      if (k == 1) chk(pins_word() == (fin ? 4'b1010 : 4'b1110), "R3", pins_word(), fin ? 4'b1010 : 4'b1110);
      else chk(pins_word() == 4'b1010, "R1", pins_word(), 4'b1010);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pins_word() == 4'b1010 && !pin_dq_oe && !busy && !ack, "R1",
          {pins_word(), pin_dq_oe, busy, ack}, 7'b1010000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(pins_word() == 4'b1010 && !pin_dq_oe, "R1", pins_word(), 4'b1010);

      // R10 ready/busy synchroniser
      chk(rb_ready == 1'b1, "R10", rb_ready, 1);
      pin_rb_n = 1'b0;
      @(negedge clk);
      chk(rb_ready == 1'b1, "R10", rb_ready, 1);
      @(negedge clk);
      chk(rb_ready == 1'b0, "R10", rb_ready, 0);
      pin_rb_n = 1'b1;

      // directed corners
      run_op(0, 8'h70, 1'b0, 0, 1'b0);
      run_op(1, 8'h12, 1'b0, 0, 1'b0);
      run_op(1, 8'h34, 1'b1, 0, 1'b0);
      run_op(2, 8'hA5, 1'b0, 15, 1'b0);
      run_op(3, 8'h00, 1'b0, 15, 1'b0);
      run_op(3, 8'h00, 1'b0, 0, 1'b1);
      run_op(0, 8'h10, 1'b0, 2, 1'b1);

      // constrained random mix
      for (int i = 0; i < 60; i++) begin
         int k = int'($urandom_range(0, 3));
         int h = ($urandom_range(0, 7) == 0) ? 15 : int'($urandom_range(0, 3));
         run_op(k, DW'($urandom), 1'($urandom), h, 1'($urandom));
      end

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule